// File: doc/BRIEF.md
# Host Source Dword Packer

The packer sits between the host write path and the blit engine during a blit whose source data comes from the host. The host writes one byte at a time. The packer places each byte into the next lane of a 32-bit accumulator. When the fourth byte arrives, it hands the completed word to the engine.

The word goes out in one of two forms, chosen by two mode inputs:

- **Split:** when colour expansion is on and dword granularity is off, the word goes out as four 8-bit units, lowest byte first.
- **Whole:** in every other mode, the word goes out as one 32-bit unit.

The output uses a valid/ready handshake. While units are still waiting for the engine, the packer holds off further host writes. A start strobe marks the beginning of a blit. It re-aligns the lane counter, clears any partial word and drops any units that are still pending.

Top module: `hsrc_word_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `wr_ready` is 1.
- R2: The n-th byte accepted since reset or start (counting from 0, modulo 4) lands in bits [8n+7:8n] of the word. The first byte therefore fills bits 7:0.
- R3: No output unit appears until the fourth byte of a word has been accepted.
- R4: With `mode_expand`=1 and `mode_dword`=0, a word leaves as four units with `out_wide`=0. The byte sits in `out_data`[7:0] and bits 31:8 are zero. The units come in the order bits 7:0, 15:8, 23:16, 31:24.
- R5: With any other mode setting, a word leaves as a single unit with `out_wide`=1 and the full word in `out_data`.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_wide` hold their values.
- R7: While any unit of a word is pending, `wr_ready` is 0. A byte offered during that time is ignored and does not enter the next word.
- R8: A cycle with `start`=1 clears the lane counter and any partial bytes. It also drops any pending units, so `out_valid` is 0 in the next cycle.
- R9: A reset during a partly filled word discards those bytes and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Blit start strobe; re-aligns and flushes |
| mode_expand | input | 1 | Colour-expand mode |
| mode_dword | input | 1 | Dword-granularity mode |
| wr_valid | input | 1 | Host byte write request |
| wr_data | input | 8 | Host byte |
| wr_ready | output | 1 | Packer can take a byte |
| out_valid | output | 1 | Unit available to the engine |
| out_ready | input | 1 | Engine accepts the unit |
| out_data | output | 32 | Unit data; an 8-bit unit is in bits 7:0 |
| out_wide | output | 1 | 1 = 32-bit unit, 0 = 8-bit unit |

## Verification
The main path is swept over all four mode combinations, with several words of different byte values in each. This separates the split form from the whole form and exposes any lane swap or wrong byte order.

The same sweep is repeated with the engine ready only every other cycle. This shows that stalls neither lose nor duplicate units.

Directed cases cover the remaining behaviour:
- A byte offered during a stall, which must not reach the next word.
- A start pulse part-way through a word, and another while a split word is waiting.
- A reset part-way through a word.

Each of these must leave the next word cleanly aligned to lane 0.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    typedef enum logic {
        UNIT_BYTE = 1'b0,
        UNIT_WORD = 1'b1
    } unit_kind_e;
endpackage

// File: rtl/hsp_lane_acc.sv
module hsp_lane_acc #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     wr_en_i,
    input  logic [BYTE_W-1:0]        wr_byte_i,
    output logic                     word_done_o,
    output logic [LANES*BYTE_W-1:0]  word_o
);
    localparam int WORD_W = LANES * BYTE_W;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [WORD_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [WORD_W-1:0] merged;

    // Lane merge: only the addressed lane takes the new byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] =
            (wr_en_i && st_q.lane == LANE_W'(g)) ? wr_byte_i
                                                  : st_q.acc[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d        = st_q;
        word_done_o = 1'b0;
        if (clear_i) begin
            st_d.lane = '0;
            st_d.acc  = '0;
        end else if (wr_en_i) begin
            st_d.acc = merged;
            if (st_q.lane == LAST_LANE) begin
                st_d.lane   = '0;
                word_done_o = 1'b1;
            end else begin
                st_d.lane = st_q.lane + LANE_W'(1);
            end
        end
    end

    assign word_o = merged;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsp_unit_emit.sv
module hsp_unit_emit
    import hsp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     load_i,
    input  logic [LANES*BYTE_W-1:0]  word_i,
    input  logic                     split_i,
    output logic                     busy_o,
    output logic                     out_valid_o,
    input  logic                     out_ready_i,
    output logic [LANES*BYTE_W-1:0]  out_data_o,
    output logic                     out_wide_o
);
    localparam int WORD_W = LANES * BYTE_W;
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    typedef struct packed {
        logic              busy;
        logic              split;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
    } emit_state_t;

    emit_state_t st_d, st_q;
    logic [BYTE_W-1:0] sel_byte;

    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (st_q.idx == IDX_W'(i)) sel_byte = st_q.word[i*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.busy = 1'b0;
            st_d.idx  = '0;
        end else if (load_i) begin
            st_d.busy  = 1'b1;
            st_d.split = split_i;
            st_d.idx   = '0;
            st_d.word  = word_i;
        end else if (st_q.busy && out_ready_i) begin
            if (!st_q.split || st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    assign busy_o      = st_q.busy;
    assign out_valid_o = st_q.busy;
    assign out_wide_o  = st_q.split ? UNIT_BYTE : UNIT_WORD;
    assign out_data_o  = st_q.split ? {{(WORD_W-BYTE_W){1'b0}}, sel_byte} : st_q.word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsrc_word_packer.sv
module hsrc_word_packer #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_expand,
    input  logic              mode_dword,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_wide
);
    logic              busy;
    logic              wr_en;
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic              split_mode;

    assign wr_ready   = !busy;
    assign wr_en      = wr_valid && !busy && !start;
    assign split_mode = mode_expand && !mode_dword;

    hsp_lane_acc #(.LANES(LANES), .BYTE_W(BYTE_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start),
        .wr_en_i     (wr_en),
        .wr_byte_i   (wr_data),
        .word_done_o (word_done),
        .word_o      (word)
    );

    hsp_unit_emit #(.LANES(LANES), .BYTE_W(BYTE_W)) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start),
        .load_i      (word_done),
        .word_i      (word),
        .split_i     (split_mode),
        .busy_o      (busy),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_data_o  (out_data),
        .out_wide_o  (out_wide)
    );
endmodule

// File: rtl/hsp_checker.sv
module hsp_checker #(
    parameter int LANES  = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_wide
);
    localparam int CW = (LANES > 1) ? $clog2(LANES) : 1;
    logic [CW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     seen <= '0;
        else if (start)                 seen <= '0;
        else if (wr_valid && wr_ready)  seen <= seen + CW'(1);
    end

    a_r3_fourth_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(seen) == CW'(LANES - 1)) && $past(wr_valid && wr_ready && !start));

    a_r4_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_data[WORD_W-1:8] == '0));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data) && $stable(out_wide)));

    a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !wr_ready);

    a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !out_valid);
endmodule

bind hsrc_word_packer hsp_checker #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_wide  (out_wide)
);

// File: tb/hsrc_word_packer_bench.sv
module hsrc_word_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_expand = 1'b0;
    logic        mode_dword = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_ready;
    logic        out_valid;
    logic        rdy_man = 1'b1;
    logic        tog_en = 1'b0;
    logic        tog = 1'b0;
    logic        out_ready;
    logic [31:0] out_data;
    logic        out_wide;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] got_data [0:63];
    logic        got_wide [0:63];
    int          got_n = 0;

    always #2 clk = ~clk;
    always @(negedge clk) tog <= ~tog;
    assign out_ready = tog_en ? tog : rdy_man;

    hsrc_word_packer u_hsrc_word_packer (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mode_expand(mode_expand), .mode_dword(mode_dword),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_wide(out_wide)
    );

    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready && got_n < 64) begin
            got_data[got_n] = out_data;
            got_wide[got_n] = out_wide;
            got_n = got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) wr_byte(w[i*8 +: 8]);
    endtask

    // Compare units recorded from index mark against the expected form of word w.
    task automatic expect_word(input int mark, input logic [31:0] w, input bit split, input string req);
        if (split) begin
            check(got_n - mark == 4, req, 32'(got_n - mark), 32'd4);
            for (int i = 0; i < 4; i++) begin
                if (mark + i < got_n) begin
                    check(got_data[mark+i] == {24'h0, w[i*8 +: 8]}, req, got_data[mark+i], {24'h0, w[i*8 +: 8]});
                    check(got_wide[mark+i] == 1'b0, req, 32'(got_wide[mark+i]), 32'd0);
                end
            end
        end else begin
            check(got_n - mark == 1, req, 32'(got_n - mark), 32'd1);
            if (mark < got_n) begin
                check(got_data[mark] == w, req, got_data[mark], w);
                check(got_wide[mark] == 1'b1, req, 32'(got_wide[mark]), 32'd1);
            end
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int mark;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
        check(wr_ready == 1'b1, "R1", 32'(wr_ready), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5: sweep modes and data, engine always ready, then toggling ready (R6)
        for (int pass = 0; pass < 2; pass++) begin
            tog_en = (pass == 1);
            for (int m = 0; m < 4; m++) begin
                mode_expand = m[1];
                mode_dword  = m[0];
                for (int k = 0; k < 3; k++) begin
                    w = 32'h01020304 * (k + 1) ^ (32'h5A3C96F1 >> m) ^ (32'(pass) << 17);
                    mark = got_n;
                    wr_word(w);
                    repeat (12) @(negedge clk);
                    expect_word(mark, w, m == 2, (m == 2) ? "R4 R2" : "R5 R2");
                end
            end
        end
        tog_en = 1'b0;
        rdy_man = 1'b1;

        // R3: three bytes produce nothing
        mode_expand = 1'b0; mode_dword = 1'b0;
        mark = got_n;
        for (int i = 0; i < 3; i++) wr_byte(8'hC0 + 8'(i));
        repeat (4) @(negedge clk);
        check(got_n == mark && !out_valid, "R3", 32'(got_n - mark), 32'd0);
        wr_byte(8'hC3);
        repeat (4) @(negedge clk);
        expect_word(mark, 32'hC3C2C1C0, 1'b0, "R3");

        // R6 R7: stall in split mode, offer a byte during the stall
        mode_expand = 1'b1; mode_dword = 1'b0;
        rdy_man = 1'b0;
        mark = got_n;
        wr_word(32'h44332211);
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            check(out_valid == 1'b1 && out_data == 32'h11 && out_wide == 1'b0, "R6", out_data, 32'h11);
            check(wr_ready == 1'b0, "R7", 32'(wr_ready), 32'd0);
            wr_valid = 1'b1; wr_data = 8'hEE;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        rdy_man = 1'b1;
        repeat (8) @(negedge clk);
        expect_word(mark, 32'h44332211, 1'b1, "R6");
        mode_expand = 1'b0;
        mark = got_n;
        wr_word(32'h8899AABB);
        repeat (4) @(negedge clk);
        expect_word(mark, 32'h8899AABB, 1'b0, "R7");

        // R8: start part-way through a word
        mark = got_n;
        wr_byte(8'h71); wr_byte(8'h72);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wr_word(32'hD4D3D2D1);
        repeat (4) @(negedge clk);
        expect_word(mark, 32'hD4D3D2D1, 1'b0, "R8");

        // R8: start while split units are pending
        mode_expand = 1'b1;
        rdy_man = 1'b0;
        mark = got_n;
        wr_word(32'h0F0E0D0C);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(out_valid == 1'b0, "R8", 32'(out_valid), 32'd0);
        rdy_man = 1'b1;
        repeat (4) @(negedge clk);
        check(got_n == mark, "R8", 32'(got_n - mark), 32'd0);

        // R9: reset part-way through a word
        mode_expand = 1'b0;
        mark = got_n;
        wr_byte(8'h91); wr_byte(8'h92); wr_byte(8'h93);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(got_n == mark && !out_valid, "R9", 32'(got_n - mark), 32'd0);
        wr_word(32'hE4E3E2E1);
        repeat (4) @(negedge clk);
        expect_word(mark, 32'hE4E3E2E1, 1'b0, "R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule